// File: doc/BRIEF.md
# Two-Wire Bus Master Byte Controller

This block drives the controller side of a two-wire serial bus (SCL clock, SDA data) for a small processor. Software gives one command at a time: open a transfer, send a byte, receive a byte, or close the transfer. The open command produces a START, or a repeated START if the bus is already held. It then sends a calling byte made from a 7-bit target address and a direction bit. After each byte the block handles the acknowledge bit. On bytes it sends, it records the acknowledge it receives. On bytes it receives, it supplies the acknowledge itself.

The SCL rate is the input clock divided by a power of two, chosen by a 3-bit speed code. A restart request can be armed before a byte. When that byte's acknowledge completes, the block then sends a repeated START and the address again without further commands. If the target refuses the byte instead, the block gives up the bus with a STOP. Both pins are open-drain: the block only ever pulls a line low or lets it float. Only SDA is read back.

Top module: `twi_byte_master`

## Requirements
- R1: After reset both lines are released, `busy`, `bus_owned`, `restart_pend` and `nack_flag` read 0, `rx_ack` reads 1, and the speed code is 001, so the first transfer runs at an SCL period of 64 clocks.
- R2: A speed code c written through `speed_we` while idle gives an SCL period of exactly 32·2^c input clocks, measured between SCL rising edges within a byte.
- R3: SDA changes only while SCL is low, except that START (SDA falling with SCL high) and STOP (SDA rising with SCL high) each appear exactly once per open or close command. `scl_oe` and `sda_oe` never change in the same cycle.
- R4: The open command (`cmd_op`=0) sends the calling byte {slave_addr[6:0], rd_dir} MSB first, where `rd_dir`=0 means write and 1 means read.
- R5: A write command (`cmd_op`=1) sends `tx_data` MSB first and samples the ninth bit. `rx_ack` becomes 0 when the target pulled SDA low there.
- R6: A missing acknowledge after the calling byte or after a written byte sets `rx_ack` and `nack_flag`. `nack_flag` holds until `nack_clr` is pulsed.
- R7: A read command (`cmd_op`=2) releases SDA for 8 bits and assembles them MSB first into `rx_data`. On the ninth bit it drives ACK (low) when `cmd_last`=0 and leaves NACK (high) when `cmd_last`=1.
- R8: With `restart_pend` set (by a `restart_set` pulse), an acknowledged byte is followed at once by a repeated START and the calling byte built from the current `slave_addr` and `rd_dir`. `restart_pend` clears and the bus stays held.
- R9: With `restart_pend` set, a non-acknowledged byte is followed by a STOP. `restart_pend` and `bus_owned` clear. Whenever the block is idle without owning the bus, both lines are released.
- R10: While `enable` is 0 every command is ignored. Write, read and close commands (`cmd_op`=1, 2, 3) are also ignored while the bus is not owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; commands are accepted only when high |
| speed_we | input | 1 | Load `speed_sel` into the speed code (idle only) |
| speed_sel | input | 3 | SCL divider code: period = 32·2^code clocks |
| slave_addr | input | 7 | Target address for the calling byte |
| rd_dir | input | 1 | Direction bit of the calling byte (1 = read) |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 0 open, 1 write byte, 2 read byte, 3 close |
| cmd_last | input | 1 | Read command: this is the final byte (send NACK) |
| tx_data | input | 8 | Byte for the write command |
| restart_set | input | 1 | Pulse: arm an automatic repeated START |
| nack_clr | input | 1 | Pulse: clear `nack_flag` |
| busy | output | 1 | A command is in progress |
| bus_owned | output | 1 | START issued and no STOP yet |
| restart_pend | output | 1 | Automatic restart armed |
| rx_ack | output | 1 | Last acknowledge received (0 = acknowledged) |
| nack_flag | output | 1 | Sticky missing-acknowledge flag |
| rx_data | output | 8 | Last byte received |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
Every bus bit takes four quarter phases of 8·2^code clocks, so each bit ends 32·2^code clocks after it starts. `busy` falls on the same clock edge that writes the status fields of the command. That edge includes any automatic repeated START, address or STOP that a restart adds. The bench therefore waits until `busy` reads low at a falling clock edge and only then samples `rx_ack`, `nack_flag`, `rx_data` and `restart_pend`. The bus model logs each byte, acknowledge and START/STOP as it happens. SCL period checks use the cycle count between the last two SCL rising edges, which always fall inside one byte.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } twi_op_e;

  typedef enum logic [1:0] {
    BK_START,
    BK_STOP,
    BK_WR,
    BK_RD
  } bit_kind_e;

  // {scl_oe, sda_oe} for quarter q of a bit of kind k carrying value v
  function automatic logic [1:0] phase_drive(bit_kind_e k, logic v, logic [1:0] q);
    logic [1:0] r;
    case (k)
      BK_START: begin
        case (q)
          2'd0:    r = 2'b10;
          2'd1:    r = 2'b00;
          2'd2:    r = 2'b01;
          default: r = 2'b11;
        endcase
      end
      BK_STOP: begin
        case (q)
          2'd0:    r = 2'b11;
          2'd1:    r = 2'b01;
          default: r = 2'b00;
        endcase
      end
      default: begin
        r[1] = (q == 2'd0) || (q == 2'd3);
        r[0] = (k == BK_WR) ? ~v : 1'b0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/twi_qtick.sv
module twi_qtick #(
  parameter int QBASE = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] spd,
  output logic             qtick
);
  localparam int QMAX = QBASE << ((1 << SEL_W) - 1);
  localparam int CW   = $clog2(QMAX) + 1;

  logic [CW-1:0] cnt_q, cnt_d, qlen;

  assign qlen  = CW'(QBASE) << spd;
  assign qtick = run && (cnt_q == qlen - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (run)  cnt_d = qtick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine
  import twi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_go,
  input  bit_kind_e kind,
  input  logic      val,
  input  logic      qtick,
  input  logic      sda_in,
  output logic      active,
  output logic      bit_done,
  output logic      rx_bit,
  output logic      scl_oe,
  output logic      sda_oe
);
  logic       act_q, act_d;
  logic [1:0] q_q, q_d;
  bit_kind_e  kind_q, kind_d;
  logic       val_q, val_d;
  logic [1:0] drv_q, drv_d;
  logic       rxb_q, rxb_d;

  assign active   = act_q;
  assign bit_done = act_q && qtick && (q_q == 2'd3);
  assign rx_bit   = rxb_q;
  assign scl_oe   = drv_q[1];
  assign sda_oe   = drv_q[0];

  always_comb begin
    act_d  = act_q;
    q_d    = q_q;
    kind_d = kind_q;
    val_d  = val_q;
    drv_d  = drv_q;
    rxb_d  = rxb_q;
    if (bit_go) begin
      act_d  = 1'b1;
      q_d    = 2'd0;
      kind_d = kind;
      val_d  = val;
      drv_d  = phase_drive(kind, val, 2'd0);
    end else if (act_q && qtick) begin
      if (q_q == 2'd2) rxb_d = sda_in;
      if (q_q == 2'd3) begin
        act_d = 1'b0;
      end else begin
        q_d   = q_q + 2'd1;
        drv_d = phase_drive(kind_q, val_q, q_q + 2'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      q_q    <= 2'd0;
      kind_q <= BK_STOP;
      val_q  <= 1'b1;
      drv_q  <= 2'b00;
      rxb_q  <= 1'b1;
    end else begin
      act_q  <= act_d;
      q_q    <= q_d;
      kind_q <= kind_d;
      val_q  <= val_d;
      drv_q  <= drv_d;
      rxb_q  <= rxb_d;
    end
  end
endmodule

// File: rtl/twi_byte_master.sv
module twi_byte_master
  import twi_pkg::*;
#(
  parameter int QBASE   = 8,
  parameter int SEL_W   = 3,
  parameter int SPD_RST = 1,
  parameter int DW      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             speed_we,
  input  logic [SEL_W-1:0] speed_sel,
  input  logic [DW-2:0]    slave_addr,
  input  logic             rd_dir,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_last,
  input  logic [DW-1:0]    tx_data,
  input  logic             restart_set,
  input  logic             nack_clr,
  output logic             busy,
  output logic             bus_owned,
  output logic             restart_pend,
  output logic             rx_ack,
  output logic             nack_flag,
  output logic [DW-1:0]    rx_data,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  localparam int BW = $clog2(DW + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} st_e;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic [1:0] sda_sync_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sda_sync_q <= 2'b11;
    else        sda_sync_q <= {sda_sync_q[0], sda_i};
  end

  st_e              st_q, st_d;
  logic [BW-1:0]    bitn_q, bitn_d;
  logic [DW-1:0]    sh_q, sh_d, rxd_q, rxd_d;
  logic             rd_q, rd_d, last_q, last_d, owned_q, owned_d;
  logic             rstp_q, rstp_d, rxack_q, rxack_d, nack_q, nack_d;
  logic [SEL_W-1:0] spd_q, spd_d;

  logic      accept, go, bv, qtick, eng_active, bit_done, rx_bit;
  bit_kind_e bk;

  assign accept = enable && cmd_valid && (st_q == S_IDLE) &&
                  ((cmd_op == OP_START) || owned_q);

  always_comb begin
    st_d    = st_q;
    bitn_d  = bitn_q;
    sh_d    = sh_q;
    rxd_d   = rxd_q;
    rd_d    = rd_q;
    last_d  = last_q;
    owned_d = owned_q;
    rstp_d  = rstp_q | restart_set;
    rxack_d = rxack_q;
    nack_d  = nack_q & ~nack_clr;
    spd_d   = (speed_we && st_q == S_IDLE) ? speed_sel : spd_q;
    case (st_q)
      S_IDLE: if (accept) begin
        case (cmd_op)
          OP_START: begin st_d = S_START; owned_d = 1'b1; end
          OP_WRITE: begin
            st_d = S_BYTE; bitn_d = '0; sh_d = tx_data; rd_d = 1'b0;
          end
          OP_READ: begin
            st_d = S_BYTE; bitn_d = '0; sh_d = '0; rd_d = 1'b1; last_d = cmd_last;
          end
          default: st_d = S_STOP;
        endcase
      end
      S_START: if (bit_done) begin
        st_d = S_BYTE; bitn_d = '0; sh_d = {slave_addr, rd_dir}; rd_d = 1'b0;
      end
      S_BYTE: if (bit_done) begin
        if (bitn_q != BW'(DW)) begin
          bitn_d = bitn_q + BW'(1);
          sh_d   = {sh_q[DW-2:0], rd_q ? rx_bit : 1'b0};
        end else begin
          if (!rd_q) begin
            rxack_d = rx_bit;
            if (rx_bit) nack_d = 1'b1;
          end else begin
            rxd_d = sh_q;
          end
          if (rstp_q) begin
            rstp_d = 1'b0;
            st_d   = (!rd_q && rx_bit) ? S_STOP : S_START;
          end else begin
            st_d = S_IDLE;
          end
        end
      end
      default: if (bit_done) begin st_d = S_IDLE; owned_d = 1'b0; end
    endcase
  end

  // next bus bit, derived from the state being entered
  always_comb begin
    go = (st_d != S_IDLE) && (accept || bit_done);
    bk = BK_WR;
    bv = 1'b1;
    case (st_d)
      S_START: bk = BK_START;
      S_STOP:  bk = BK_STOP;
      S_BYTE: begin
        if (bitn_d == BW'(DW)) begin
          bk = rd_d ? BK_WR : BK_RD;
          bv = last_d;
        end else begin
          bk = rd_d ? BK_RD : BK_WR;
          bv = sh_d[DW-1];
        end
      end
      default: bk = BK_WR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= S_IDLE;
      bitn_q  <= '0;
      sh_q    <= '0;
      rxd_q   <= '0;
      rd_q    <= 1'b0;
      last_q  <= 1'b0;
      owned_q <= 1'b0;
      rstp_q  <= 1'b0;
      rxack_q <= 1'b1;
      nack_q  <= 1'b0;
      spd_q   <= SEL_W'(SPD_RST);
    end else begin
      st_q    <= st_d;
      bitn_q  <= bitn_d;
      sh_q    <= sh_d;
      rxd_q   <= rxd_d;
      rd_q    <= rd_d;
      last_q  <= last_d;
      owned_q <= owned_d;
      rstp_q  <= rstp_d;
      rxack_q <= rxack_d;
      nack_q  <= nack_d;
      spd_q   <= spd_d;
    end
  end

  twi_qtick #(.QBASE(QBASE), .SEL_W(SEL_W)) tick_i (
    .clk(clk), .rst_n(rst_i), .restart(go), .run(eng_active),
    .spd(spd_q), .qtick(qtick)
  );

  twi_bit_engine eng_i (
    .clk(clk), .rst_n(rst_i), .bit_go(go), .kind(bk), .val(bv),
    .qtick(qtick), .sda_in(sda_sync_q[1]), .active(eng_active),
    .bit_done(bit_done), .rx_bit(rx_bit), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign busy         = (st_q != S_IDLE);
  assign bus_owned    = owned_q;
  assign restart_pend = rstp_q;
  assign rx_ack       = rxack_q;
  assign nack_flag    = nack_q;
  assign rx_data      = rxd_q;
endmodule

// File: rtl/twi_byte_master_chk.sv
module twi_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic nack_clr,
  input logic nack_flag,
  input logic busy,
  input logic bus_owned,
  input logic scl_oe,
  input logic sda_oe
);
  assert_one_line_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(scl_oe) || $stable(sda_oe));

  assert_nack_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_flag && !nack_clr) |=> nack_flag);

  assert_free_bus_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_owned) |-> (!scl_oe && !sda_oe));

  assert_disabled_stays_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy) |=> !busy);
endmodule

bind twi_byte_master twi_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .nack_clr(nack_clr),
  .nack_flag(nack_flag), .busy(busy), .bus_owned(bus_owned),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/twi_byte_master_tb_top.sv
module twi_byte_master_tb_top;
  import twi_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable, speed_we, rd_dir, cmd_valid, cmd_last, restart_set, nack_clr;
  logic [2:0] speed_sel;
  logic [6:0] slave_addr;
  logic [1:0] cmd_op;
  logic [7:0] tx_data, rx_data;
  logic       busy, bus_owned, restart_pend, rx_ack, nack_flag, scl_oe, sda_oe, sda_i;
  logic       slv_drv;

  always #4 clk = ~clk;

  assign sda_i = ~(sda_oe | slv_drv);

  twi_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_we(speed_we),
    .speed_sel(speed_sel), .slave_addr(slave_addr), .rd_dir(rd_dir),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_last(cmd_last),
    .tx_data(tx_data), .restart_set(restart_set), .nack_clr(nack_clr),
    .busy(busy), .bus_owned(bus_owned), .restart_pend(restart_pend),
    .rx_ack(rx_ack), .nack_flag(nack_flag), .rx_data(rx_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  // ---------------- bus target model ----------------
  int         cyc, t_rise, per, bcnt, nlog, nm, n_start, n_stop;
  logic       p_scl, p_sda, tx_mode, is_addr, rd_req, m_ack, nack_mode;
  logic [7:0] sh, txb;
  logic [7:0] slog [0:31];
  logic       macks [0:31];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      p_scl = 1'b1; p_sda = 1'b1; bcnt = 0; tx_mode = 1'b0; is_addr = 1'b0;
      slv_drv <= 1'b0;
    end else begin
      if (p_scl && !scl_oe && p_sda && !sda_i) begin
        n_start = n_start + 1; bcnt = 0; tx_mode = 1'b0; is_addr = 1'b1; slv_drv <= 1'b0;
      end else if (p_scl && !scl_oe && !p_sda && sda_i) begin
        n_stop = n_stop + 1; bcnt = 0; tx_mode = 1'b0; slv_drv <= 1'b0;
      end else if (!p_scl && !scl_oe) begin
        per = cyc - t_rise; t_rise = cyc;
        if (bcnt < 8) sh = {sh[6:0], sda_i};
        else if (tx_mode) begin m_ack = sda_i; macks[nm] = sda_i; nm = nm + 1; end
        bcnt = bcnt + 1;
      end else if (p_scl && scl_oe) begin
        if (bcnt == 8) begin
          if (!tx_mode) begin
            slog[nlog] = sh; nlog = nlog + 1;
            if (is_addr) rd_req = sh[0];
            slv_drv <= ~nack_mode;
          end else slv_drv <= 1'b0;
        end else if (bcnt == 9) begin
          bcnt = 0;
          if (is_addr) tx_mode = rd_req & ~nack_mode;
          else if (tx_mode) begin
            if (m_ack) tx_mode = 1'b0; else txb = txb + 8'd1;
          end
          is_addr = 1'b0;
          slv_drv <= tx_mode & ~txb[7];
        end else if (tx_mode && bcnt >= 1 && bcnt <= 7) begin
          slv_drv <= ~txb[7 - bcnt];
        end
      end
      p_scl = !scl_oe;
      p_sda = sda_i;
    end
  end

  // ---------------- checking ----------------
  int tests = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic last);
    @(negedge clk); cmd_op = op; cmd_last = last; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic pulse_cmd(input logic [1:0] op);
    @(negedge clk); cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  // {speed code[2:0], address[6:0], expected SCL period[13:0]}
  localparam logic [23:0] SPD_VEC [4] = '{
    {3'd0, 7'h0F, 14'd32},
    {3'd2, 7'h71, 14'd128},
    {3'd3, 7'h2C, 14'd256},
    {3'd1, 7'h55, 14'd64}
  };

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s0, p0, l0, m0;
    logic [23:0] v;
    cyc = 0; t_rise = 0; per = 0; nlog = 0; nm = 0; n_start = 0; n_stop = 0;
    sh = '0; txb = 8'h00; nack_mode = 1'b0; rd_req = 1'b0; m_ack = 1'b0;
    rst_n = 1'b0; enable = 1'b1; speed_we = 1'b0; speed_sel = '0; slave_addr = '0;
    rd_dir = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_last = 1'b0; tx_data = '0;
    restart_set = 1'b0; nack_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
    chk("R1 flags", {bus_owned, restart_pend, nack_flag, rx_ack}, 4'b0001);

    // R1 default speed code gives 64-clock period
    slave_addr = 7'h50; l0 = nlog;
    do_cmd(OP_START, 1'b0);
    chk("R1 default period", per, 64);
    chk("R4 default address", slog[l0], 8'hA0);
    chk("R5 address ack", rx_ack, 0);
    do_cmd(OP_STOP, 1'b0);

    // R2/R3/R4 vector walk
    for (int i = 0; i < 4; i++) begin
      v = SPD_VEC[i];
      @(negedge clk); speed_sel = v[23:21]; speed_we = 1'b1;
      @(negedge clk); speed_we = 1'b0;
      slave_addr = v[20:14]; rd_dir = 1'b0;
      s0 = n_start; l0 = nlog;
      do_cmd(OP_START, 1'b0);
      chk("R2 period", per, int'(v[13:0]));
      chk("R4 calling byte", slog[l0], {v[20:14], 1'b0});
      chk("R3 one START", n_start, s0 + 1);
      p0 = n_stop;
      do_cmd(OP_STOP, 1'b0);
      chk("R3 one STOP", n_stop, p0 + 1);
      chk("R9 released", {bus_owned, scl_oe, sda_oe}, 0);
    end

    // R5 write with ack, R6 write without ack
    slave_addr = 7'h2A; l0 = nlog;
    do_cmd(OP_START, 1'b0);
    tx_data = 8'hA5;
    do_cmd(OP_WRITE, 1'b0);
    chk("R5 data on bus", slog[l0 + 1], 8'hA5);
    chk("R5 rx_ack", rx_ack, 0);
    chk("R5 no nack", nack_flag, 0);
    nack_mode = 1'b1; tx_data = 8'h3C;
    do_cmd(OP_WRITE, 1'b0);
    chk("R6 data nack rx_ack", rx_ack, 1);
    chk("R6 data nack flag", nack_flag, 1);
    repeat (20) @(negedge clk);
    chk("R6 flag sticky", nack_flag, 1);
    nack_clr = 1'b1; @(negedge clk); nack_clr = 1'b0; @(negedge clk);
    chk("R6 flag cleared", nack_flag, 0);
    do_cmd(OP_STOP, 1'b0);

    // R6 address not acknowledged
    slave_addr = 7'h13;
    do_cmd(OP_START, 1'b0);
    chk("R6 address nack flag", nack_flag, 1);
    nack_mode = 1'b0;
    nack_clr = 1'b1; @(negedge clk); nack_clr = 1'b0;
    do_cmd(OP_STOP, 1'b0);

    // R7 read two bytes
    slave_addr = 7'h11; rd_dir = 1'b1; txb = 8'h9C; m0 = nm; l0 = nlog;
    do_cmd(OP_START, 1'b0);
    chk("R4 read calling byte", slog[l0], 8'h23);
    do_cmd(OP_READ, 1'b0);
    chk("R7 first byte", rx_data, 8'h9C);
    chk("R7 master ACK", macks[m0], 0);
    do_cmd(OP_READ, 1'b1);
    chk("R7 second byte", rx_data, 8'h9D);
    chk("R7 master NACK on last", macks[m0 + 1], 1);
    p0 = n_stop;
    do_cmd(OP_STOP, 1'b0);
    chk("R3 STOP after read", n_stop, p0 + 1);

    // R8 restart after acknowledged byte
    slave_addr = 7'h22; rd_dir = 1'b0; s0 = n_start; l0 = nlog;
    do_cmd(OP_START, 1'b0);
    @(negedge clk); restart_set = 1'b1; @(negedge clk); restart_set = 1'b0;
    chk("R8 armed", restart_pend, 1);
    rd_dir = 1'b1; tx_data = 8'h77; txb = 8'h4E;
    do_cmd(OP_WRITE, 1'b0);
    chk("R8 data byte", slog[l0 + 1], 8'h77);
    chk("R8 resent address", slog[l0 + 2], 8'h45);
    chk("R8 repeated START", n_start, s0 + 2);
    chk("R8 pend cleared, bus held", {restart_pend, bus_owned}, 2'b01);
    do_cmd(OP_READ, 1'b1);
    chk("R8 read after restart", rx_data, 8'h4E);
    do_cmd(OP_STOP, 1'b0);

    // R9 restart with refused byte
    slave_addr = 7'h33; rd_dir = 1'b0;
    do_cmd(OP_START, 1'b0);
    @(negedge clk); restart_set = 1'b1; @(negedge clk); restart_set = 1'b0;
    nack_mode = 1'b1; tx_data = 8'h55; p0 = n_stop;
    do_cmd(OP_WRITE, 1'b0);
    chk("R9 nack flag", nack_flag, 1);
    chk("R9 STOP issued", n_stop, p0 + 1);
    chk("R9 pend and owner cleared", {restart_pend, bus_owned}, 0);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    nack_mode = 1'b0;
    nack_clr = 1'b1; @(negedge clk); nack_clr = 1'b0;

    // R10 ignored commands
    enable = 1'b0; s0 = n_start;
    pulse_cmd(OP_START);
    chk("R10 disabled busy", busy, 0);
    repeat (100) @(negedge clk);
    chk("R10 disabled no START", n_start, s0);
    chk("R10 disabled no owner", bus_owned, 0);
    enable = 1'b1;
    pulse_cmd(OP_WRITE);
    chk("R10 write without bus", busy, 0);
    repeat (50) @(negedge clk);
    chk("R10 lines idle", {scl_oe, sda_oe}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule